// File: doc/BRIEF.md
# FIR Output Saturation and Shift Stage

This stage sits behind the multiply-accumulate array of a programmable FIR filter. It receives the 27-bit signed accumulator result, which has 6 integer bits above 21 fractional bits. It first clamps the value to a programmable word length. It then brings the result to a 24-bit output word. If the clamped word is longer than 24 bits, the surplus low bits are rounded away. If it is shorter, zeros are appended at the bottom. Last, a programmable shift moves the word left or right by up to three places.

Two 3-bit control inputs set the behaviour. One sets how many upper bits the clamp removes. The other sets the shift. Both controls are taken with each valid sample, so consecutive samples may use different settings. The result appears a fixed two cycles after the sample is accepted.

Top module: `fir_sat_shift_stage`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0 and out_data_o is 0.
- R2: A sample accepted with in_valid_i at clock edge n produces out_valid_o = 1 after edge n+1. out_valid_o is 0 in every cycle that has no such sample.
- R3: With sat_sel_i = s, the accumulator value is clamped to a signed word of L = 27 - s bits. A value above 2^(L-1)-1 becomes that maximum, and a value below -2^(L-1) becomes that minimum. The clamp step is always present, even though it has no effect for s = 0.
- R4: For s = 0, 1 or 2, the clamped word has L - 24 low bits removed by round-half-up: add half of the kept LSB, then drop the bits (floor). A positive result that then exceeds 0x7FFFFF is held at 0x7FFFFF.
- R5: For s = 3, the clamped word is the 24-bit result. For s = 4 to 7, the 24-bit result is the clamped L-bit word followed by 24 - L zero bits at the LSB end.
- R6: shift_sel_i values 3'b001, 3'b010 and 3'b011 shift the 24-bit word left by 1, 2 and 3. Zeros enter at the LSB. Bits shifted past bit 23 are lost, with no saturation.
- R7: shift_sel_i values 3'b111, 3'b110 and 3'b101 shift the word right by 1, 2 and 3. Zeros enter at the MSB.
- R8: shift_sel_i values 3'b000 and the reserved 3'b100 leave the word unshifted.
- R9: sat_sel_i and shift_sel_i are sampled together with each sample. Back-to-back samples with different settings each use their own settings.
- R10: out_data_o keeps its last value while no new result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample qualifier |
| acc_i | input | 27 | Accumulator value, signed, 6 integer and 21 fractional bits |
| sat_sel_i | input | 3 | Number of upper bits removed by the clamp |
| shift_sel_i | input | 3 | Shift code |
| out_valid_o | output | 1 | Result qualifier |
| out_data_o | output | 24 | Saturated, normalised and shifted result |

## Verification
The hardest case to reach is the re-saturation after rounding. It needs a word that is already at its positive clamp limit and that also has the half bit set, so that rounding carries into the sign position. The stimulus reaches it by driving the full-scale positive accumulator with the widest setting, where the clamp leaves the value unchanged and the rounding overflows. A sweep then applies every pair of clamp and shift codes to values near the limits of each word length, with back-to-back samples that change settings on every cycle.

// File: rtl/fir_satsh_pkg.sv
package fir_satsh_pkg;
  localparam int ACC_W = 27;
  localparam int OUT_W = 24;
  localparam int SEL_W = 3;
  localparam int NSEL  = 1 << SEL_W;

  typedef logic [ACC_W-1:0] acc_t;
  typedef logic [OUT_W-1:0] word_t;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/fir_satsh_clamp.sv
module fir_satsh_clamp
  import fir_satsh_pkg::*;
(
  input  acc_t acc_i,
  input  sel_t sel_i,
  output acc_t clamp_o
);
  acc_t cand [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_len
    localparam int L = ACC_W - g;
    always_comb begin
      if (acc_i[ACC_W-1:L-1] == {(g+1){acc_i[ACC_W-1]}})
        cand[g] = acc_i;
      else if (acc_i[ACC_W-1])
        cand[g] = {{(g+1){1'b1}}, {(L-1){1'b0}}};
      else
        cand[g] = {{(g+1){1'b0}}, {(L-1){1'b1}}};
    end
  end

  assign clamp_o = cand[sel_i];
endmodule

// File: rtl/fir_satsh_norm.sv
module fir_satsh_norm
  import fir_satsh_pkg::*;
(
  input  acc_t  clamp_i,
  input  sel_t  sel_i,
  output word_t norm_o
);
  word_t cand [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_len
    localparam int L = ACC_W - g;
    if (L > OUT_W) begin : g_round
      localparam int K = L - OUT_W;
      logic [OUT_W:0] t;
      // floor(x / 2^K) plus the half bit equals round-half-up
      assign t = {clamp_i[L-1], clamp_i[L-1:K]} + (OUT_W+1)'(clamp_i[K-1]);
      assign cand[g] = (t[OUT_W:OUT_W-1] == 2'b01) ? {1'b0, {(OUT_W-1){1'b1}}}
                                                   : t[OUT_W-1:0];
    end else if (L == OUT_W) begin : g_keep
      assign cand[g] = clamp_i[OUT_W-1:0];
    end else begin : g_pad
      assign cand[g] = {clamp_i[L-1:0], {(OUT_W-L){1'b0}}};
    end
  end

  assign norm_o = cand[sel_i];
endmodule

// File: rtl/fir_satsh_shift.sv
module fir_satsh_shift
  import fir_satsh_pkg::*;
(
  input  word_t data_i,
  input  sel_t  code_i,
  output word_t data_o
);
  localparam sel_t RSVD = sel_t'(1) << (SEL_W-1);

  always_comb begin
    if (!code_i[SEL_W-1])
      data_o = data_i << code_i;
    else if (code_i == RSVD)
      data_o = data_i;
    else
      data_o = data_i >> (sel_t'(0) - code_i);
  end
endmodule

// File: rtl/fir_sat_shift_stage.sv
module fir_sat_shift_stage
  import fir_satsh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SEL_W-1:0] sat_sel_i,
  input  logic [SEL_W-1:0] shift_sel_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  acc_t  clamped;
  word_t norm;
  word_t s1_data;
  sel_t  s1_shift;
  logic  s1_valid;
  word_t shifted;

  fir_satsh_clamp u_clamp (.acc_i(acc_i), .sel_i(sat_sel_i), .clamp_o(clamped));
  fir_satsh_norm  u_norm  (.clamp_i(clamped), .sel_i(sat_sel_i), .norm_o(norm));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_shift <= '0;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_data  <= norm;
        s1_shift <= shift_sel_i;
      end
    end
  end

  fir_satsh_shift u_shift (.data_i(s1_data), .code_i(s1_shift), .data_o(shifted));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= s1_valid;
      if (s1_valid) out_data_o <= shifted;
    end
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 out_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !out_valid_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid |=> $stable(out_data_o));
  a_r8_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_shift == 3'b100) |=> out_data_o == $past(s1_data));
  a_r7_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_shift[2] && s1_shift[1:0] != 2'b00) |=> !out_data_o[OUT_W-1]);
  a_r6_lsb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && !s1_shift[2] && s1_shift != 3'b000) |=> !out_data_o[0]);
endmodule

// File: tb/tb_fir_sat_shift_stage.sv
module tb_fir_sat_shift_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [26:0] acc_i = '0;
  logic [2:0]  sat_sel_i = '0;
  logic [2:0]  shift_sel_i = '0;
  logic        out_valid_o;
  logic [23:0] out_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fir_sat_shift_stage dut (.*);

  function automatic logic [23:0] model(logic [26:0] acc, int sat, int sh);
    longint a, mx, mn, c, t;
    int l, k;
    logic [23:0] y;
    a  = longint'($signed(acc));
    l  = 27 - sat;
    mx = (64'sd1 <<< (l-1)) - 1;
    mn = -mx - 1;
    c  = (a > mx) ? mx : (a < mn) ? mn : a;
    if (l > 24) begin
      k = l - 24;
      t = (c + (64'sd1 <<< (k-1))) >>> k;
      if (t > 64'sd8388607) t = 64'sd8388607;
    end else t = c <<< (24 - l);
    y = t[23:0];
    if (sh >= 1 && sh <= 3) y = y << sh;
    else if (sh >= 5) y = y >> (8 - sh);
    return y;
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    check(tag, {23'd0, act}, {23'd0, exp});
  endtask

  task automatic run_one(string tag, logic [26:0] acc, int sat, int sh, logic [23:0] exp);
    @(negedge clk_i);
    in_valid_i = 1'b1; acc_i = acc; sat_sel_i = 3'(sat); shift_sel_i = 3'(sh);
    @(negedge clk_i);
    in_valid_i = 1'b0; acc_i = ~acc; sat_sel_i = ~3'(sat); shift_sel_i = ~3'(sh);
    check_bit({tag, " R2 early"}, out_valid_o, 1'b0);
    @(negedge clk_i);
    check_bit({tag, " R2 valid"}, out_valid_o, 1'b1);
    check(tag, out_data_o, exp);
  endtask

  task automatic test_reset();
    check_bit("R1 valid", out_valid_o, 1'b0);
    check("R1 data", out_data_o, 24'h0);
  endtask

  task automatic test_clamp();
    run_one("R3 in range", 27'h0000123, 3, 0, 24'h000123);
    run_one("R3 pos clamp", 27'h0800000, 3, 0, 24'h7FFFFF);
    run_one("R3 neg clamp", 27'h7700000, 3, 0, 24'h800000);
    run_one("R3 R5 21-bit clamp", 27'h0100000, 6, 0, 24'h7FFFF8);
  endtask

  task automatic test_round();
    run_one("R4 12", 27'd12, 0, 0, 24'h000002);
    run_one("R4 11", 27'd11, 0, 0, 24'h000001);
    run_one("R4 -12", 27'h7FFFFF4, 0, 0, 24'hFFFFFF);
    run_one("R4 -13", 27'h7FFFFF3, 0, 0, 24'hFFFFFE);
    run_one("R4 resat", 27'h3FFFFFF, 0, 0, 24'h7FFFFF);
    run_one("R4 half 3", 27'd3, 2, 0, 24'h000002);
    run_one("R4 -1", 27'h7FFFFFF, 2, 0, 24'h000000);
  endtask

  task automatic test_pad();
    run_one("R5 sat7", 27'd1, 7, 0, 24'h000010);
    run_one("R5 sat7 clamp", 27'h0080000, 7, 0, 24'h7FFFF0);
    run_one("R5 sat4 neg", 27'h7FFFFFF, 4, 0, 24'hFFFFFE);
  endtask

  task automatic test_shift();
    run_one("R6 left3", 27'h0400001, 3, 3, 24'h000008);
    run_one("R6 left1", 27'h0400001, 3, 1, 24'h800002);
    run_one("R6 left2", 27'h0000003, 3, 2, 24'h00000C);
    run_one("R7 right1", 27'h7FFFFFE, 3, 7, 24'h7FFFFF);
    run_one("R7 right2", 27'h7FFFFFE, 3, 6, 24'h3FFFFF);
    run_one("R7 right3", 27'h7FFFFFE, 3, 5, 24'h1FFFFF);
    run_one("R8 reserved", 27'h7FFFFFE, 3, 4, 24'hFFFFFE);
    run_one("R8 none", 27'h7FFFFFE, 3, 0, 24'hFFFFFE);
  endtask

  task automatic test_back_to_back();
    logic [26:0] a [3] = '{27'h0800000, 27'd12, 27'd1};
    int s [3] = '{3, 0, 7};
    int h [3] = '{7, 0, 3};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        check_bit("R9 valid", out_valid_o, 1'b1);
        check("R9 data", out_data_o, model(a[i-2], s[i-2], h[i-2]));
      end
      if (i < 3) begin
        in_valid_i = 1'b1; acc_i = a[i]; sat_sel_i = 3'(s[i]); shift_sel_i = 3'(h[i]);
      end else in_valid_i = 1'b0;
    end
  endtask

  task automatic test_hold();
    logic [23:0] last;
    run_one("R10 setup", 27'h0012345, 3, 0, 24'h012345);
    last = out_data_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      acc_i = 27'(i * 7919 + 5); sat_sel_i = 3'(i); shift_sel_i = 3'(i + 1);
      check_bit("R10 valid low", out_valid_o, 1'b0);
      check("R10 hold", out_data_o, last);
    end
  endtask

  task automatic test_sweep();
    logic [26:0] vals [4] = '{27'h3FFFFFF, 27'h4000000, 27'h00FFFFF, 27'h7F7FFFB};
    for (int s = 0; s < 8; s++)
      for (int h = 0; h < 8; h++)
        for (int v = 0; v < 4; v++)
          run_one("R3 R4 R5 R6 R7 sweep", vals[v], s, h, model(vals[v], s, h));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    test_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    test_clamp();
    test_round();
    test_pad();
    test_shift();
    test_back_to_back();
    test_hold();
    test_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule